// File: doc/BRIEF.md
# Programmable Flag Threshold Sequencer

This block keeps the two thresholds that a FIFO's almost-empty and almost-full flag logic compares against. Each threshold is sixteen bits, held as a low byte and a high byte, which gives four byte-wide storage slots. One shared two-bit index picks the slot that the next configuration access uses. Every write or read-back moves the index on by one, and it wraps around after the last slot.

When the configuration select is low, the write enable loads the data input into the selected slot. In the same mode, the pair of read enables copies the selected slot onto the byte output. When the select is high, the block does nothing and the FIFO runs its normal traffic. A load may stop after any number of bytes. The next configuration access then continues at the following slot, not at the first one. The two thresholds are sent to the flag comparators continuously, cut down to the FIFO's address width. Both sides of the block share one clock, which is the FIFO's coincident-clock case.

Top module: `flag_ofs_seq`

## Requirements
- R1: While reset is held and just after it, both thresholds read 7, the byte output is 0 and the index points at slot 0.
- R2: A rising edge with cfg_sel_n=0 and wr_en_n=0 stores wr_data into the selected slot and moves the index to the next slot.
- R3: The slot order is 0 = empty low byte, 1 = empty high byte, 2 = full low byte, 3 = full high byte. The slot after 3 is 0.
- R4: Raising cfg_sel_n between accesses leaves the index where it is, so the next access continues at the following slot.
- R5: cfg_sel_n=0 with wr_en_n=1 and no read request changes no slot and does not move the index.
- R6: A rising edge with cfg_sel_n=0, both read enables low and wr_en_n=1 puts the selected slot on rd_data after that edge and moves the index on by one.
- R7: If cfg_sel_n=1 or either read enable is high, no read-back takes place: rd_data keeps its value and the index stays put.
- R8: ae_level is {slot1,slot0} and af_level is {slot3,slot2}, each keeping only its lowest ADDR_W bits. The bits above that have no effect.
- R9: If a write and a read-back are requested on the same edge, only the write happens. rd_data keeps its value and the index moves by exactly one.
- R10: While cfg_sel_n=1, the write and read enables change neither threshold nor the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sel_n | input | 1 | Configuration access select, active low |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| wr_data | input | BYTE_W | Byte to store in the selected slot |
| rd_data | output | BYTE_W | Registered copy of the last slot read back |
| ae_level | output | ADDR_W | Almost-empty threshold |
| af_level | output | ADDR_W | Almost-full threshold |

## Verification
The hardest state to reach from the ports is an index that sits part-way through the cycle after a partial load. A block that restarts at slot 0 looks the same as a correct one until a later access falls on the wrong slot. The stimulus stops a load after two bytes, sends idle and no-op edges, and then continues. It runs the load past slot 3 so that the index wraps, then reads the slots back one by one so that each byte shows which slot the index was on. A simultaneous write and read request, followed by one more read-back, shows that the index moved by exactly one step.

// File: rtl/ofs_seq_pkg.sv
package ofs_seq_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);

  typedef enum logic [IDX_W-1:0] {
    SLOT_AE_LO = 2'd0,
    SLOT_AE_HI = 2'd1,
    SLOT_AF_LO = 2'd2,
    SLOT_AF_HI = 2'd3
  } slot_e;

  // Index of the slot after the current one, wrapping after the last slot.
  function automatic logic [IDX_W-1:0] slot_next(input logic [IDX_W-1:0] cur);
    return (cur == IDX_W'(NUM_REGS-1)) ? '0 : cur + 1'b1;
  endfunction

  // Builds a 16-bit threshold from its low and high bytes.
  function automatic logic [2*BYTE_W-1:0] join_bytes(input logic [BYTE_W-1:0] lo,
                                                     input logic [BYTE_W-1:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/ofs_seq_ptr.sv
module ofs_seq_ptr
  import ofs_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] sel
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel <= SLOT_AE_LO;
    else if (step) sel <= slot_next(sel);
  end

endmodule

// File: rtl/ofs_seq_bank.sv
module ofs_seq_bank
  import ofs_seq_pkg::*;
#(
  parameter int unsigned DEF_LEVEL = 7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 sel,
  input  logic [BYTE_W-1:0]                din,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]  bank
);

  localparam logic [2*BYTE_W-1:0] DEF_WORD = (2*BYTE_W)'(DEF_LEVEL);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    localparam logic [BYTE_W-1:0] RST_VAL =
      (g % 2 == 0) ? DEF_WORD[BYTE_W-1:0] : DEF_WORD[2*BYTE_W-1:BYTE_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                bank[g] <= RST_VAL;
      else if (wr_en && (sel == IDX_W'(g)))      bank[g] <= din;
    end
  end

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> bank[$past(sel)] == $past(din)); // R2
  AST_BANK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank)); // R10

endmodule

// File: rtl/ofs_seq_rdbk.sv
module ofs_seq_rdbk
  import ofs_seq_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd_en,
  input  logic [IDX_W-1:0]                 sel,
  input  logic [NUM_REGS-1:0][BYTE_W-1:0]  bank,
  output logic [BYTE_W-1:0]                dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dout <= '0;
    else if (rd_en) dout <= bank[sel];
  end

  AST_RB_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> dout == $past(bank[sel])); // R6
  AST_RB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(dout)); // R7

endmodule

// File: rtl/flag_ofs_seq.sv
module flag_ofs_seq
  import ofs_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DEF_LEVEL = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel_n,
  input  logic              wr_en_n,
  input  logic              rd_en_a_n,
  input  logic              rd_en_b_n,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] ae_level,
  output logic [ADDR_W-1:0] af_level
);

  // Named events for the assertions
  logic                            load_hit;
  logic                            readback_req;
  logic                            readback_hit;
  logic                            step;
  logic [IDX_W-1:0]                sel;
  logic [NUM_REGS-1:0][BYTE_W-1:0] bank;
  logic [2*BYTE_W-1:0]             ae_word;
  logic [2*BYTE_W-1:0]             af_word;

  assign load_hit     = !cfg_sel_n && !wr_en_n;
  assign readback_req = !cfg_sel_n && !rd_en_a_n && !rd_en_b_n;
  assign readback_hit = readback_req && !load_hit;   // write side has priority
  assign step         = load_hit || readback_hit;

  ofs_seq_ptr u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .sel   (sel)
  );

  ofs_seq_bank #(.DEF_LEVEL(DEF_LEVEL)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (load_hit),
    .sel   (sel),
    .din   (wr_data),
    .bank  (bank)
  );

  ofs_seq_rdbk u_rdbk (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (readback_hit),
    .sel   (sel),
    .bank  (bank),
    .dout  (rd_data)
  );

  always_comb begin
    ae_word  = join_bytes(bank[SLOT_AE_LO], bank[SLOT_AE_HI]);
    af_word  = join_bytes(bank[SLOT_AF_LO], bank[SLOT_AF_HI]);
    ae_level = ae_word[ADDR_W-1:0];
    af_level = af_word[ADDR_W-1:0];
  end

  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sel == IDX_W'(NUM_REGS-1)) |=> sel == '0); // R3
  AST_SELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel_n |=> $stable(sel)); // R4
  AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hit && readback_req) |=> $stable(rd_data)); // R9
  AST_LEVELS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel_n |=> ($stable(ae_level) && $stable(af_level))); // R10

endmodule

// File: tb/flag_ofs_seq_test.sv
`timescale 1ns/1ps
module flag_ofs_seq_test;

  typedef struct packed {
    logic        cfg_n;
    logic        wr_n;
    logic        ra_n;
    logic        rb_n;
    logic [7:0]  din;
    logic [7:0]  exp_q;
    logic [15:0] exp_ae;
    logic [15:0] exp_af;
    logic [3:0]  req;
  } vec_t;

  // Starts from the reset state. ADDR_W=13, so thresholds keep 13 bits.
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b1,1'b1,8'h12,8'h00,16'h0012,16'h0007,4'd2},  // R2 slot0
    '{1'b0,1'b0,1'b1,1'b1,8'h34,8'h00,16'h1412,16'h0007,4'd8},  // R8 upper bits dropped
    '{1'b1,1'b0,1'b1,1'b1,8'hAA,8'h00,16'h1412,16'h0007,4'd10}, // R10
    '{1'b0,1'b1,1'b1,1'b1,8'hBB,8'h00,16'h1412,16'h0007,4'd5},  // R5 no-op
    '{1'b0,1'b0,1'b1,1'b1,8'h56,8'h00,16'h1412,16'h0056,4'd4},  // R4 resumes at slot2
    '{1'b0,1'b0,1'b1,1'b1,8'hFF,8'h00,16'h1412,16'h1F56,4'd8},  // R8
    '{1'b0,1'b0,1'b1,1'b1,8'h9A,8'h00,16'h149A,16'h1F56,4'd3},  // R3 wrap to slot0
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h34,16'h149A,16'h1F56,4'd6},  // R6 slot1
    '{1'b0,1'b1,1'b0,1'b1,8'h00,8'h34,16'h149A,16'h1F56,4'd7},  // R7
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h56,16'h149A,16'h1F56,4'd6},  // R6 slot2
    '{1'b1,1'b1,1'b0,1'b0,8'h00,8'h56,16'h149A,16'h1F56,4'd7},  // R7
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'hFF,16'h149A,16'h1F56,4'd6},  // R6 slot3
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h9A,16'h149A,16'h1F56,4'd3},  // R3 read wraps
    '{1'b0,1'b0,1'b0,1'b0,8'h11,8'h9A,16'h119A,16'h1F56,4'd9},  // R9 write wins
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h56,16'h119A,16'h1F56,4'd9}   // R9 single step
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sel_n = 1'b1;
  logic        wr_en_n = 1'b1;
  logic        rd_en_a_n = 1'b1;
  logic        rd_en_b_n = 1'b1;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [12:0] ae_level;
  logic [12:0] af_level;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flag_ofs_seq uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_sel_n (cfg_sel_n),
    .wr_en_n   (wr_en_n),
    .rd_en_a_n (rd_en_a_n),
    .rd_en_b_n (rd_en_b_n),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .ae_level  (ae_level),
    .af_level  (af_level)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic w, input logic a, input logic b,
                       input logic [7:0] d);
    cfg_sel_n = c; wr_en_n = w; rd_en_a_n = a; rd_en_b_n = b; wr_data = d;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "q in reset", {8'h0, rd_data}, 16'h0000);
    chk("R1", "ae in reset", {3'b0, ae_level}, 16'h0007);
    chk("R1", "af in reset", {3'b0, af_level}, 16'h0007);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].cfg_n, VEC[i].wr_n, VEC[i].ra_n, VEC[i].rb_n, VEC[i].din);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d", VEC[i].req, i), "q", {8'h0, rd_data}, {8'h0, VEC[i].exp_q});
      chk($sformatf("R%0d vec%0d", VEC[i].req, i), "ae", {3'b0, ae_level}, VEC[i].exp_ae);
      chk($sformatf("R%0d vec%0d", VEC[i].req, i), "af", {3'b0, af_level}, VEC[i].exp_af);
    end

    // R1: reset in mid-sequence restores defaults and the index
    drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "q after reset", {8'h0, rd_data}, 16'h0000);
    chk("R1", "ae after reset", {3'b0, ae_level}, 16'h0007);
    chk("R1", "af after reset", {3'b0, af_level}, 16'h0007);
    rst_n = 1'b1;
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    chk("R1", "index back at slot0", {8'h0, rd_data}, 16'h0007);
    @(negedge clk);
    chk("R3", "slot1 default", {8'h0, rd_data}, 16'h0000);

    // R10: enables with the select high touch nothing; index stays at slot2
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h55);
    @(negedge clk);
    chk("R10", "ae unchanged", {3'b0, ae_level}, 16'h0007);
    chk("R10", "af unchanged", {3'b0, af_level}, 16'h0007);
    chk("R10", "q unchanged", {8'h0, rd_data}, 16'h0000);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    chk("R10", "index still slot2", {8'h0, rd_data}, 16'h0007);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule